// File: doc/BRIEF.md
# CAN Transmit Error Counter with Fault Confinement State

This block keeps the transmit error count of a CAN node and derives the node's fault confinement state from it. The protocol engine feeds it single-cycle strobes: a transmit error together with a cause code, a successful transmission, a flag that is high while arbitration is in progress, and a flag saying whether any dominant bit was observed while the node was sending its passive error flag. The block outputs the current count and one of three states: error active, error passive or bus off.

Most transmit errors raise the count by a fixed step and every successful frame lowers it by one. Two kinds of error are exempt and leave the count untouched. The first is a stuff error raised during arbitration. The second is an acknowledge error reported while the node is error passive, when no dominant bit was seen during the passive error flag. The second exemption covers a node that is alone on the bus. Such a node never gets an acknowledgment and retransmits forever, but it stays error passive and never drifts into bus off. Once in bus off, the counter freezes until a recovery input clears it.

Top module: `can_tx_fault_tracker`

## Requirements
- R1: After reset the count is 0 and the state output is error active (2'b00).
- R2: A counted transmit error adds 8 to the count. Cause codes are 3 bits: 1 = stuff error, 3 = acknowledge error; every other code (0, 2, 4 to 7) is always counted.
- R3: A transmit error with cause 1 (stuff) while the arbitration flag is high leaves the count unchanged; with the arbitration flag low it is counted.
- R4: A transmit error with cause 3 (acknowledge) while the state is error passive and the dominant-seen flag is low leaves the count unchanged; in error active, or with the dominant-seen flag high, it is counted.
- R5: A successful transmission subtracts 1 from the count; at 0 the count stays 0.
- R6: When a counted error and a success arrive in the same cycle, only the +8 is applied; an exempt error in the same cycle as a success does not block the decrement.
- R7: Outside bus off, the state is error passive (2'b01) when the count is 128 or more and error active (2'b00) below 128.
- R8: A counted error that would take the count above 255 sets the count to 255 and the state to bus off (2'b10).
- R9: In bus off every error and success strobe is ignored: count and state hold.
- R10: The recovery input clears the count to 0 and returns the state to error active in any state, taking priority over strobes in the same cycle.
- R11: Starting from error passive, an unbroken run of acknowledge errors with the dominant-seen flag low never moves the node into bus off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_i | input | 1 | Bus-off recovery: clears count and state |
| tx_err_i | input | 1 | Transmit error strobe |
| err_cause_i | input | 3 | Cause of the transmit error (1 stuff, 3 acknowledge, others generic) |
| arb_phase_i | input | 1 | High while arbitration is in progress |
| dom_seen_i | input | 1 | A dominant bit was seen during the passive error flag |
| tx_ok_i | input | 1 | Successful transmission strobe |
| tec_o | output | 8 | Current transmit error count |
| fc_state_o | output | 2 | 00 error active, 01 error passive, 10 bus off |

## Verification
The assertions assume every input is a known value in each cycle after reset and that a cause code only matters in a cycle where the error strobe is high; the recovery input may arrive at any time, including together with strobes. The assertions on exemptions only claim the count holds when no success and no recovery share the cycle, because those would legitimately move it. The stimulus changes all inputs half a cycle away from the sampling edge, always drives defined values, and combines directed runs with pseudo-random strobes weighted heavily enough toward errors to cross the passive and bus-off thresholds many times.

// File: rtl/tec_pkg.sv
package tec_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_t;

  localparam logic [2:0] CAUSE_STUFF = 3'd1;
  localparam logic [2:0] CAUSE_ACK   = 3'd3;

  // Stuff error raised while arbitration is running is not charged.
  function automatic logic arb_stuff_exempt(input logic [2:0] cause,
                                            input logic       arb);
    return (cause == CAUSE_STUFF) && arb;
  endfunction

  // Acknowledge error in error passive with a quiet passive error flag
  // is not charged (covers the lone-node retransmission loop).
  function automatic logic quiet_ack_exempt(input logic [2:0] cause,
                                            input logic       passive,
                                            input logic       dom_seen);
    return (cause == CAUSE_ACK) && passive && !dom_seen;
  endfunction

endpackage

// File: rtl/tec_event_filter.sv
module tec_event_filter
  import tec_pkg::*;
(
  input  logic       err_i,
  input  logic [2:0] cause_i,
  input  logic       arb_i,
  input  logic       dom_seen_i,
  input  logic       passive_i,
  output logic       counted_o,
  output logic       exempt_o
);

  logic exempt_arb;
  logic exempt_ack;

  always_comb begin
    exempt_arb = arb_stuff_exempt(cause_i, arb_i);
    exempt_ack = quiet_ack_exempt(cause_i, passive_i, dom_seen_i);
    exempt_o   = err_i && (exempt_arb || exempt_ack);
    counted_o  = err_i && !exempt_arb && !exempt_ack;
  end

  // An error strobe is either charged or exempt, never both (R2).
  always_comb begin
    assert_counted_xor_exempt_R2: assert (!(counted_o && exempt_o));
  end

endmodule

// File: rtl/tec_count_core.sv
module tec_count_core #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned ERR_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             boff_o
);

  localparam int unsigned WIDE_W = CNT_W + 1;
  localparam logic [WIDE_W-1:0] CNT_MAX_W = {1'b0, {CNT_W{1'b1}}};
  localparam logic [WIDE_W-1:0] STEP_W    = WIDE_W'(ERR_STEP);

  function automatic logic [WIDE_W-1:0] add_step(input logic [CNT_W-1:0] v);
    return {1'b0, v} + STEP_W;
  endfunction

  function automatic logic [CNT_W-1:0] floor_dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic              boff_q;
  logic [WIDE_W-1:0] stepped;
  logic              step_ovf;
  logic              step_apply;
  logic              dec_apply;

  always_comb begin
    stepped    = add_step(cnt_q);
    step_ovf   = stepped > CNT_MAX_W;
    step_apply = inc_i && !boff_q && !recover_i;
    dec_apply  = dec_i && !inc_i && !boff_q && !recover_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      boff_q <= 1'b0;
    end else if (recover_i) begin
      cnt_q  <= '0;
      boff_q <= 1'b0;
    end else if (step_apply) begin
      if (step_ovf) begin
        cnt_q  <= '1;
        boff_q <= 1'b1;
      end else begin
        cnt_q  <= stepped[CNT_W-1:0];
      end
    end else if (dec_apply) begin
      cnt_q <= floor_dec(cnt_q);
    end
  end

  assign count_o = cnt_q;
  assign boff_o  = boff_q;

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !boff_q && !recover_i && !step_ovf)
      |=> (count_o == $past(count_o) + CNT_W'(ERR_STEP)));

  assert_floor_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !recover_i && count_o == '0) |=> (count_o == '0));

  assert_dec_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !recover_i && !boff_q && count_o != '0)
      |=> (count_o == $past(count_o) - 1'b1));

  assert_busoff_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_q && !recover_i) |=> ($stable(count_o) && boff_o));

  assert_recover_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recover_i |=> (count_o == '0 && !boff_o));

  assert_overflow_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !boff_q && !recover_i && step_ovf) |=> (boff_o && count_o == '1));

endmodule

// File: rtl/tec_state_map.sv
module tec_state_map
  import tec_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PASSIVE_AT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             boff_i,
  output fc_state_t        state_o,
  output logic             passive_o
);

  localparam logic [CNT_W-1:0] PASSIVE_TH = CNT_W'(PASSIVE_AT);

  always_comb begin
    if (boff_i)                    state_o = FC_BUSOFF;
    else if (count_i >= PASSIVE_TH) state_o = FC_PASSIVE;
    else                           state_o = FC_ACTIVE;
    passive_o = (state_o == FC_PASSIVE);
  end

  // Bus off is only ever entered with the counter saturated (R8).
  assert_busoff_saturated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boff_i |-> (count_i == '1));

  // Leaving bus off only lands in error active with a cleared count (R10).
  assert_busoff_exit_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boff_i) |-> (count_i == '0 && state_o == FC_ACTIVE));

endmodule

// File: rtl/can_tx_fault_tracker.sv
module can_tx_fault_tracker
  import tec_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned ERR_STEP   = 8,
  parameter int unsigned PASSIVE_AT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_i,
  input  logic             tx_err_i,
  input  logic [2:0]       err_cause_i,
  input  logic             arb_phase_i,
  input  logic             dom_seen_i,
  input  logic             tx_ok_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [1:0]       fc_state_o
);

  logic             err_counted;
  logic             err_exempt;
  logic             is_passive;
  logic             is_busoff;
  logic [CNT_W-1:0] count;
  fc_state_t        state;

  tec_event_filter u_filter (
    .err_i      (tx_err_i),
    .cause_i    (err_cause_i),
    .arb_i      (arb_phase_i),
    .dom_seen_i (dom_seen_i),
    .passive_i  (is_passive),
    .counted_o  (err_counted),
    .exempt_o   (err_exempt)
  );

  tec_count_core #(
    .CNT_W    (CNT_W),
    .ERR_STEP (ERR_STEP)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .recover_i (recover_i),
    .inc_i     (err_counted),
    .dec_i     (tx_ok_i),
    .count_o   (count),
    .boff_o    (is_busoff)
  );

  tec_state_map #(
    .CNT_W      (CNT_W),
    .PASSIVE_AT (PASSIVE_AT)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_i   (count),
    .boff_i    (is_busoff),
    .state_o   (state),
    .passive_o (is_passive)
  );

  assign tec_o      = count;
  assign fc_state_o = state;

  assert_arb_stuff_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err_i && err_cause_i == CAUSE_STUFF && arb_phase_i && !tx_ok_i && !recover_i)
      |=> $stable(tec_o));

  assert_quiet_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err_i && err_cause_i == CAUSE_ACK && fc_state_o == FC_PASSIVE
     && !dom_seen_i && !tx_ok_i && !recover_i) |=> $stable(tec_o));

  assert_exempt_no_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_exempt && !recover_i && fc_state_o != FC_BUSOFF)
      |=> (tec_o <= $past(tec_o)));

  assert_inc_beats_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_counted && tx_ok_i && !recover_i && fc_state_o != FC_BUSOFF)
      |=> ((tec_o > $past(tec_o)) || (fc_state_o == FC_BUSOFF)));

  assert_lone_node_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o == FC_PASSIVE && tx_err_i && err_cause_i == CAUSE_ACK
     && !dom_seen_i && !tx_ok_i && !recover_i) |=> (fc_state_o == FC_PASSIVE));

  assert_state_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o != 2'b11));

endmodule

// File: tb/can_tx_fault_tracker_tb.sv
module can_tx_fault_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       recover_i;
  logic       tx_err_i;
  logic [2:0] err_cause_i;
  logic       arb_phase_i;
  logic       dom_seen_i;
  logic       tx_ok_i;
  logic [7:0] tec_o;
  logic [1:0] fc_state_o;

  int n_cmp  = 0;
  int n_bad  = 0;
  int m_cnt  = 0;
  bit m_boff = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  can_tx_fault_tracker dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .recover_i   (recover_i),
    .tx_err_i    (tx_err_i),
    .err_cause_i (err_cause_i),
    .arb_phase_i (arb_phase_i),
    .dom_seen_i  (dom_seen_i),
    .tx_ok_i     (tx_ok_i),
    .tec_o       (tec_o),
    .fc_state_o  (fc_state_o)
  );

  function automatic int exp_state();
    if (m_boff) return 2;
    if (m_cnt >= 128) return 1;
    return 0;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (int'(tec_o) != m_cnt || int'(fc_state_o) != exp_state()) begin
      n_bad++;
      $display("FAIL %s: tec=%0d state=%0d expected tec=%0d state=%0d",
               tag, tec_o, fc_state_o, m_cnt, exp_state());
    end
  endtask

  // One clock: drive at the falling edge, advance the model, compare at the next falling edge.
  task automatic cyc(input bit e, input bit [2:0] c, input bit a, input bit d,
                     input bit k, input bit r, input string tag);
    bit passive;
    bit charged;
    tx_err_i = e; err_cause_i = c; arb_phase_i = a;
    dom_seen_i = d; tx_ok_i = k; recover_i = r;
    passive = !m_boff && (m_cnt >= 128);
    charged = e && !(c == 3'd1 && a) && !(c == 3'd3 && passive && !d);
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_boff = 1'b0;
    end else if (!m_boff) begin
      if (charged) begin
        if (m_cnt + 8 > 255) begin m_cnt = 255; m_boff = 1'b1; end
        else m_cnt = m_cnt + 8;
      end else if (k && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL WATCHDOG: run hung, tec=%0d expected run end", tec_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; recover_i = 0; tx_err_i = 0; err_cause_i = 0;
    arb_phase_i = 0; dom_seen_i = 0; tx_ok_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");

    // R2: generic causes charge +8
    cyc(1, 3'd0, 0, 0, 0, 0, "R2 bit");
    cyc(1, 3'd2, 0, 0, 0, 0, "R2 form");
    cyc(1, 3'd4, 0, 0, 0, 0, "R2 crc");
    cyc(1, 3'd7, 1, 1, 0, 0, "R2 other");
    // R3
    cyc(1, 3'd1, 1, 0, 0, 0, "R3 stuff in arb");
    cyc(1, 3'd1, 0, 0, 0, 0, "R3 stuff outside arb");
    // R4 while active: counted
    cyc(1, 3'd3, 0, 0, 0, 0, "R4 ack active");
    // R5
    for (int i = 0; i < 60; i++) cyc(0, 3'd0, 0, 0, 1, 0, "R5 decrement");
    cyc(0, 3'd0, 0, 0, 1, 0, "R5 floor");
    // R6
    cyc(1, 3'd0, 0, 0, 1, 0, "R6 inc wins");
    cyc(1, 3'd1, 1, 0, 1, 0, "R6 exempt with ok");
    // R7: climb to passive
    while (m_cnt < 128) cyc(1, 3'd5, 0, 0, 0, 0, "R7 climb");
    cyc(0, 3'd0, 0, 0, 0, 0, "R7 passive");
    // R4 in passive
    cyc(1, 3'd3, 0, 0, 0, 0, "R4 quiet ack passive");
    cyc(1, 3'd3, 0, 1, 0, 0, "R4 ack dominant seen");
    // R11: lone node
    for (int i = 0; i < 300; i++) cyc(1, 3'd3, 0, 0, 0, 0, "R11 lone node");
    // R7: back below threshold
    while (m_cnt >= 128) cyc(0, 3'd0, 0, 0, 1, 0, "R7 fall to active");
    // R8: drive to bus off
    while (!m_boff) cyc(1, 3'd0, 0, 0, 0, 0, "R8 to bus off");
    // R9
    cyc(1, 3'd0, 0, 0, 0, 0, "R9 err ignored");
    for (int i = 0; i < 5; i++) cyc(0, 3'd0, 0, 0, 1, 0, "R9 ok ignored");
    // R10
    cyc(1, 3'd0, 0, 0, 1, 1, "R10 recover from bus off");
    cyc(1, 3'd0, 0, 0, 0, 0, "R10 count resumes");
    cyc(1, 3'd2, 0, 0, 0, 1, "R10 recover beats err");

    // Pseudo-random mixture over all requirements
    for (int i = 0; i < 4000; i++) begin
      bit e, a, d, k, r;
      bit [2:0] c;
      e = ($urandom % 100) < 45;
      c = 3'($urandom % 8);
      a = $urandom % 2;
      d = $urandom % 2;
      k = ($urandom % 100) < 40;
      r = ($urandom % 300) == 0;
      cyc(e, c, a, d, k, r, "R2..R10 mixed");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule